// File: doc/BRIEF.md
# Lane-State Stream Cipher Datapath

This block carries the five-lane, 640-bit state of an authenticated stream cipher and moves a byte stream through it, one 16-byte word at a time. For each accepted word it takes a keystream from the current lanes, combines that keystream with the data, and then folds the plaintext back into the lanes as the message of a state update. The update sends every lane through one unkeyed AES round (SubBytes, ShiftRows, MixColumns) and feeds the result into the next lane. Associated data takes the same update path but produces no output word.

An upstream key-setup stage writes a fresh state through a load port, and that load also clears the byte counters. A downstream tag stage reads the live state and the two byte counters. Data arrives on a valid/ready stream that carries a mode and a byte count. Ciphertext or plaintext leaves on a one-deep registered output stream with a per-byte keep mask. Bytes are little-endian: byte 0 sits in bits [7:0], and lane k of the state sits in bits [128k+127:128k].

Top module: `aead_stream_core`

## Requirements
- R1: The keystream word is Z = L1 ^ (L2 & L3) ^ L4, taken from the lanes before the word's update. In encrypt mode (in_mode = 2'b01) the output word is in_data ^ Z on its valid bytes.
- R2: Each accepted word with absorbed message M replaces the state as follows: L0 becomes L0 ^ A(L4) ^ M, and Lk becomes Lk ^ A(Lk-1) for k = 1..4. A is one AES round with a zero round key, so a lane of sixteen equal bytes b maps to sixteen copies of Sbox(b).
- R3: In decrypt mode (in_mode = 2'b10) the output is in_data ^ Z, and that recovered plaintext is what the state absorbs. Decrypting a ciphertext from the same starting state therefore returns the plaintext and reproduces the same final state.
- R4: in_len gives the number of valid low-order bytes, where 0 means a full word of 16. Output byte i is zero and out_keep[i] is 0 for every i at or above that count, and out_keep[i] is 1 below it.
- R5: For a partial word, the absorbed plaintext is zero in every padding byte in every mode, whatever in_data carries in those bytes. No keystream byte reaches the state.
- R6: In associated-data mode (in_mode = 2'b00, and 2'b11 is treated the same way) the word updates the state with in_data padded to the count, and no output word is produced.
- R7: ad_bytes accumulates the byte counts of associated-data words. msg_bytes accumulates the byte counts of encrypt and decrypt words.
- R8: While ld_valid is high, the state is replaced by ld_state, both counters are cleared, and in_ready is low.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_keep hold and in_ready is low.
- R10: After reset the state, both counters and out_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load a new state and clear counters |
| ld_state | input | 640 | State to load, lane k at [128k+127:128k] |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_mode | input | 2 | 00 associated data, 01 encrypt, 10 decrypt, 11 as 00 |
| in_len | input | 4 | Valid byte count, 0 = 16 |
| in_data | input | 128 | Input word, byte 0 in [7:0] |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes output |
| out_data | output | 128 | Output word, padding bytes zero |
| out_keep | output | 16 | Per-byte valid mask |
| state_o | output | 640 | Current lane state |
| ad_bytes | output | CNT_W | Associated-data bytes absorbed since load |
| msg_bytes | output | CNT_W | Message bytes processed since load |

## Verification
A corrupted lane, or a wrong S-box or MixColumns result, leaves the current word untouched because the keystream is read before the update. The error first appears in the output of the next word, one accepted word later, and it also shows at once on state_o. A zero-state known-answer run makes that keystream take the constant byte values 0x00, 0x63, 0x00 and then 0x67, so a single wrong S-box entry or a wrong lane shift changes an exact output byte. An encrypt-then-decrypt round trip with junk in the padding bytes catches any path that lets ciphertext or keystream into the state, because the two final states would then differ.

// File: rtl/aead_lane_pkg.sv
package aead_lane_pkg;
    localparam int NB     = 16;
    localparam int WORD_W = NB * 8;
    localparam int NLANE  = 5;
    localparam int ST_W   = NLANE * WORD_W;
    localparam int LEN_W  = $clog2(NB);

    typedef enum logic [1:0] {
        MD_AD  = 2'b00,
        MD_ENC = 2'b01,
        MD_DEC = 2'b10,
        MD_RSV = 2'b11
    } mode_e;

    function automatic logic [7:0] xt(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = xt(x);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
        return 8'((v << k) | (v >> (8 - k)));
    endfunction

    // inverse as x^254, then affine map
    function automatic logic [7:0] sbox_f(input logic [7:0] x);
        logic [7:0] sq = x;
        logic [7:0] r  = 8'h01;
        for (int k = 0; k < 7; k++) begin
            sq = gmul(sq, sq);
            r  = gmul(r, sq);
        end
        return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
    endfunction

    function automatic logic [WORD_W-1:0] expand_keep(input logic [NB-1:0] k);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < NB; i++) m[8*i +: 8] = {8{k[i]}};
        return m;
    endfunction
endpackage

// File: rtl/aes_rnd.sv
module aes_rnd
    import aead_lane_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    output logic [WORD_W-1:0] y
);
    for (genvar c = 0; c < 4; c++) begin : g_col
        logic [7:0] b0, b1, b2, b3;
        // row shift picks from column (c + r) mod 4, then substitution
        assign b0 = sbox_f(a[8*(0 + 4*((c + 0) % 4)) +: 8]);
        assign b1 = sbox_f(a[8*(1 + 4*((c + 1) % 4)) +: 8]);
        assign b2 = sbox_f(a[8*(2 + 4*((c + 2) % 4)) +: 8]);
        assign b3 = sbox_f(a[8*(3 + 4*((c + 3) % 4)) +: 8]);
        assign y[8*(4*c+0) +: 8] = xt(b0) ^ xt(b1) ^ b1 ^ b2 ^ b3;
        assign y[8*(4*c+1) +: 8] = xt(b1) ^ xt(b2) ^ b2 ^ b3 ^ b0;
        assign y[8*(4*c+2) +: 8] = xt(b2) ^ xt(b3) ^ b3 ^ b0 ^ b1;
        assign y[8*(4*c+3) +: 8] = xt(b3) ^ xt(b0) ^ b0 ^ b1 ^ b2;
    end
endmodule

// File: rtl/lane_update.sv
module lane_update
    import aead_lane_pkg::*;
(
    input  logic [ST_W-1:0]   st_i,
    input  logic [WORD_W-1:0] msg_i,
    output logic [ST_W-1:0]   st_o
);
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam int SRC = (i + NLANE - 1) % NLANE;
        logic [WORD_W-1:0] rnd;
        aes_rnd u_rnd (.a(st_i[WORD_W*SRC +: WORD_W]), .y(rnd));
        if (i == 0) begin : g_head
            assign st_o[0 +: WORD_W] = st_i[0 +: WORD_W] ^ rnd ^ msg_i;
        end else begin : g_tail
            assign st_o[WORD_W*i +: WORD_W] = st_i[WORD_W*i +: WORD_W] ^ rnd;
        end
    end
endmodule

// File: rtl/byte_mask.sv
module byte_mask
    import aead_lane_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    output logic [NB-1:0]    keep,
    output logic [LEN_W:0]   nbytes
);
    assign nbytes = (len == '0) ? (LEN_W+1)'(NB) : {1'b0, len};
    for (genvar i = 0; i < NB; i++) begin : g_k
        assign keep[i] = ((LEN_W+1)'(i) < nbytes);
    end
endmodule

// File: rtl/aead_stream_core.sv
module aead_stream_core
    import aead_lane_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [ST_W-1:0]   ld_state,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_mode,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [NB-1:0]     out_keep,
    output logic [ST_W-1:0]   state_o,
    output logic [CNT_W-1:0]  ad_bytes,
    output logic [CNT_W-1:0]  msg_bytes
);
    logic [ST_W-1:0]   st_q, st_nxt;
    logic [NB-1:0]     keep_w;
    logic [LEN_W:0]    nb_w;
    logic [WORD_W-1:0] mask_w, ks_w, plain_w, xout_w;
    mode_e             md;
    logic              fire, is_msg;

    byte_mask u_mask (.len(in_len), .keep(keep_w), .nbytes(nb_w));

    assign mask_w = expand_keep(keep_w);
    assign ks_w   = st_q[WORD_W*1 +: WORD_W]
                  ^ (st_q[WORD_W*2 +: WORD_W] & st_q[WORD_W*3 +: WORD_W])
                  ^ st_q[WORD_W*4 +: WORD_W];
    assign md      = mode_e'(in_mode);
    assign is_msg  = (md == MD_ENC) || (md == MD_DEC);
    assign xout_w  = (in_data ^ ks_w) & mask_w;
    assign plain_w = (md == MD_DEC) ? xout_w : (in_data & mask_w);

    lane_update u_upd (.st_i(st_q), .msg_i(plain_w), .st_o(st_nxt));

    assign in_ready = !ld_valid && (!out_valid || out_ready);
    assign fire     = in_valid && in_ready;
    assign state_o  = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_keep  <= '0;
            ad_bytes  <= '0;
            msg_bytes <= '0;
        end else begin
            if (out_ready) out_valid <= 1'b0;
            if (ld_valid) begin
                st_q      <= ld_state;
                ad_bytes  <= '0;
                msg_bytes <= '0;
            end else if (fire) begin
                st_q <= st_nxt;
                if (is_msg) begin
                    out_valid <= 1'b1;
                    out_data  <= xout_w;
                    out_keep  <= keep_w;
                    msg_bytes <= msg_bytes + CNT_W'(nb_w);
                end else begin
                    ad_bytes  <= ad_bytes + CNT_W'(nb_w);
                end
            end
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep));
    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);
    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_keep != '0) &&
        ((({1'b0, out_keep} + (NB+1)'(1)) & {1'b0, out_keep}) == '0));
    p_pad_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~expand_keep(out_keep)) == '0));
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> ad_bytes == '0 && msg_bytes == '0 && state_o == $past(ld_state));
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !ld_valid && !(in_valid && in_ready) |=> $stable(state_o));
    p_adq_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_mode[0] && !in_mode[1] |=> !out_valid && $stable(msg_bytes));
endmodule

// File: tb/sim_aead_stream_core.sv
module sim_aead_stream_core;
    localparam int W  = 128;
    localparam int SW = 640;

    logic clk = 0, rst = 1;
    logic ld_valid = 0;
    logic [SW-1:0] ld_state = '0;
    logic in_valid = 0, in_ready, out_valid, out_ready = 1;
    logic [1:0] in_mode = 2'b01;
    logic [3:0] in_len = 0;
    logic [W-1:0] in_data = '0, out_data;
    logic [15:0] out_keep;
    logic [SW-1:0] state_o;
    logic [31:0] ad_bytes, msg_bytes;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    aead_stream_core u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic [3:0] l, input logic [W-1:0] d);
        @(negedge clk);
        in_mode = m; in_len = l; in_data = d; in_valid = 1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic load(input logic [SW-1:0] s);
        @(negedge clk);
        ld_valid = 1; ld_state = s;
        #1 chk(in_ready == 0, "R8 in_ready during load", W'(in_ready), 0);
        @(negedge clk);
        ld_valid = 0;
        chk(ad_bytes == 0 && msg_bytes == 0, "R8 counters cleared", W'(msg_bytes), 0);
    endtask

    // zero-state known answers: keystream goes 00, 63, 00, 67 per byte
    localparam logic [W-1:0] D3 = 128'h0123456789abcdef_fedcba9876543210;
    localparam logic [W-1:0] M5 = {88'h0, 40'hff_ffff_ffff};
    localparam int NV = 4;
    localparam logic [3:0]   V_LEN [NV] = '{4'd0, 4'd0, 4'd0, 4'd5};
    localparam logic [W-1:0] V_DAT [NV] = '{{16{8'h63}}, {16{8'hfb}}, 128'h0, D3};
    localparam logic [W-1:0] V_EXP [NV] = '{{16{8'h63}}, {16{8'h98}}, 128'h0, (D3 ^ {16{8'h67}}) & M5};
    localparam logic [15:0]  V_KEEP[NV] = '{16'hffff, 16'hffff, 16'hffff, 16'h001f};

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [SW-1:0] xs, st_enc;
        logic [W-1:0] rp [3];
        logic [W-1:0] rc [3];
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(out_valid == 0, "R10 out_valid", W'(out_valid), 0);
        chk(state_o == '0, "R10 state", state_o[W-1:0], 0);
        chk(ad_bytes == 0 && msg_bytes == 0, "R10 counters", W'(ad_bytes), 0);

        // R1 R2 R4 known-answer walk
        load('0);
        for (int i = 0; i < NV; i++) begin
            send(2'b01, V_LEN[i], V_DAT[i]);
            chk(out_valid == 1, "R1 out_valid", W'(out_valid), 1);
            chk(out_data == V_EXP[i], (i == 0) ? "R1 first word" : "R2 lane update keystream", out_data, V_EXP[i]);
            chk(out_keep == V_KEEP[i], "R4 keep", W'(out_keep), W'(V_KEEP[i]));
        end
        chk(msg_bytes == 53, "R7 msg_bytes", W'(msg_bytes), 53);
        chk(ad_bytes == 0, "R7 ad_bytes", W'(ad_bytes), 0);

        // R6 associated data absorbs without output
        load('0);
        send(2'b00, 4'd0, {16{8'h63}});
        chk(out_valid == 0, "R6 no output for AD", W'(out_valid), 0);
        send(2'b01, 4'd0, {16{8'hfb}});
        chk(out_data == {16{8'h98}}, "R6 AD updates state", out_data, {16{8'h98}});
        chk(ad_bytes == 16 && msg_bytes == 16, "R7 split counts", W'(ad_bytes), 16);
        send(2'b11, 4'd3, 128'hffff);
        chk(out_valid == 0, "R6 mode 11 as AD", W'(out_valid), 0);
        chk(ad_bytes == 19, "R7 ad partial count", W'(ad_bytes), 19);

        // R9 backpressure
        out_ready = 0;
        send(2'b01, 4'd0, 128'h5a5a);
        held = out_data;
        repeat (2) @(negedge clk);
        chk(out_valid == 1 && in_ready == 0, "R9 stall", W'({out_valid, in_ready}), 2);
        chk(out_data == held, "R9 data held", out_data, held);
        out_ready = 1;
        @(negedge clk);
        chk(out_valid == 0, "R9 drained", W'(out_valid), 0);

        // R3 R5 round trip with junk padding
        for (int k = 0; k < 80; k++) xs[8*k +: 8] = 8'(k * 37 + 11);
        rp[0] = 128'h00112233_44556677_8899aabb_ccddeeff;
        rp[1] = 128'hdeadbeef_01020304_cafef00d_10203040;
        rp[2] = 128'hc3c3c3c3_c3c3c3c3_c3_13579b_df2468ac;
        load(xs);
        for (int i = 0; i < 3; i++) begin
            send(2'b01, (i == 2) ? 4'd7 : 4'd0, rp[i]);
            rc[i] = out_data;
        end
        chk((rc[2] & ~{72'h0, 56'hff_ffff_ffff_ffff}) == '0, "R4 pad bytes zero", rc[2], 0);
        st_enc = state_o;
        load(xs);
        for (int i = 0; i < 3; i++) begin
            logic [W-1:0] cin, pexp;
            cin  = (i == 2) ? (rc[2] | {72'ha5a5_a5a5_a5a5_a5a5_a5, 56'h0}) : rc[i];
            pexp = (i == 2) ? (rp[2] & {72'h0, 56'hff_ffff_ffff_ffff}) : rp[i];
            send(2'b10, (i == 2) ? 4'd7 : 4'd0, cin);
            chk(out_data == pexp, "R3 decrypt recovers plaintext", out_data, pexp);
        end
        for (int l = 0; l < 5; l++)
            chk(state_o[W*l +: W] == st_enc[W*l +: W], "R5 state matches after round trip",
                state_o[W*l +: W], st_enc[W*l +: W]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule